// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits inside a synchronous DRAM controller. It holds the mode word that the controller last wrote to the memory. For every beat of a read or write burst, it produces the column address that goes with that beat. The controller loads a 12-bit mode word with a one-cycle strobe. The block decodes the word into a burst length, a beat ordering, a CAS latency and a write policy. Any code outside the supported set is refused. A refused code raises a sticky error flag and leaves the setting that was already in force.

A burst begins with a start strobe that carries a read/write flag and a start column. Each cycle with the advance strobe high moves the burst to its next beat. Beat addresses follow one of two orders:
- Sequential: the count wraps inside the aligned block of burst-length columns.
- Interleaved: the low column bits are XORed with the beat count.

A full-page burst steps through the whole row and keeps going until a terminate strobe or a new start arrives. A new start may come on any cycle. It discards what is left of the burst in progress and runs a complete burst from the new column.

Top module: `sdram_colseq`

## Requirements
- R1: After reset, `brst_active`, `brst_last` and `cfg_err` are 0 and `cas_lat` is 2. The burst setting is one beat, sequential, and writes burst at the programmed length.
- R2: Mode word bits [2:0] set the burst length. Code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `brst_last` is high exactly during the final beat. An advance on the final beat clears `brst_active` on the next cycle.
- R3: Mode bit 3 = 0 selects sequential order. For length L, beat k has the address (start − start mod L) + ((start mod L + k) mod L).
- R4: Mode bit 3 = 1 selects interleaved order. Beat k has the address (start − start mod L) + ((start mod L) XOR k).
- R5: Length code 111 with sequential order is a full-page burst. Beat k has the address (start + k) mod 2^COL_W. `brst_last` is never raised, and the burst runs until a terminate strobe or a new start.
- R6: `brst_stop` without `brst_start` clears `brst_active` on the next cycle.
- R7: Mode bits [6:4] set the CAS latency. Code 010 gives `cas_lat` = 2 and code 011 gives `cas_lat` = 3, shown from the cycle after the load.
- R8: Some mode words hold a reserved code:
  - length code 100, 101 or 110;
  - length code 111 together with bit 3 = 1;
  - a latency code other than 010 or 011;
  - bits [11:7] other than 00000 or 00100.

  Loading such a word sets `cfg_err` from the next cycle until reset and changes no setting.
- R9: Bits [11:7] = 00000 give bursts of the programmed length for reads and writes. Bits [11:7] = 00100 (bit 9 set) turn every write burst into a single beat, while reads keep the programmed length.
- R10: A start strobe during a burst abandons the remaining beats. The new burst runs its full length from the new column.
- R11: `col_addr` is registered. It shows the start column one cycle after a start strobe and the next beat one cycle after an advance. With the advance low, `col_addr` and the burst position hold.
- R12: A start strobe takes priority over a terminate strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ld | input | 1 | Load strobe for the mode word |
| mode_word | input | 12 | Mode word value |
| brst_start | input | 1 | Burst start strobe |
| brst_write | input | 1 | 1 for a write burst, 0 for a read burst |
| brst_col | input | COL_W (8) | Start column of the burst |
| beat_adv | input | 1 | Advance to the next beat |
| brst_stop | input | 1 | Terminate the current burst |
| col_addr | output | COL_W (8) | Column address of the current beat |
| brst_active | output | 1 | A burst is in progress |
| brst_last | output | 1 | The current beat is the final one |
| cas_lat | output | 2 | CAS latency in force (2 or 3) |
| cfg_err | output | 1 | Sticky flag for a refused mode word |

## Verification
Every result has one register between the stimulus and the output. The column address, the active flag and the last-beat flag all settle one clock after the start, advance or terminate strobe that caused them. The latency and error outputs settle one clock after the mode load. The bench drives inputs on the falling edge and samples them on the next falling edge, which is exactly one rising edge after the stimulus. During a burst it checks every beat in that same cycle. The sweeps cover every valid length, both orderings, both write policies, reads and writes, and many start columns; for the 8-beat length they cover all 256 start columns.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  localparam int MODE_W = 12;
  localparam int CAS_W  = 2;

  // mode word field positions
  localparam int LEN_LSB = 0;
  localparam int ORD_BIT = 3;
  localparam int LAT_LSB = 4;
  localparam int POL_LSB = 7;

  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;
  localparam logic [2:0] LAT_2    = 3'b010;
  localparam logic [2:0] LAT_3    = 3'b011;
  localparam logic [4:0] POL_BURST  = 5'b00000;
  localparam logic [4:0] POL_WR_ONE = 5'b00100;

  typedef struct packed {
    logic [1:0] len_lg;   // log2 of burst length when not full page
    logic       len_full; // full-page burst
    logic       intl;     // interleaved ordering
    logic       cas3;     // latency 3 when set, else 2
    logic       wr_one;   // writes are single beat
  } mode_cfg_t;

  typedef struct packed {
    logic      ok;
    mode_cfg_t cfg;
  } mode_dec_t;

  localparam mode_cfg_t CFG_RESET = '{len_lg: 2'd0, len_full: 1'b0, intl: 1'b0,
                                      cas3: 1'b0, wr_one: 1'b0};

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] w);
    mode_dec_t  d;
    logic [2:0] len_c;
    logic [2:0] lat_c;
    logic [4:0] pol_c;
    len_c = w[LEN_LSB +: 3];
    lat_c = w[LAT_LSB +: 3];
    pol_c = w[POL_LSB +: 5];
    d = '0;
    d.ok = 1'b1;
    d.cfg.intl = w[ORD_BIT];
    case (len_c)
      LEN_1, LEN_2, LEN_4, LEN_8: d.cfg.len_lg = len_c[1:0];
      LEN_PAGE: begin
        d.cfg.len_full = 1'b1;
        if (w[ORD_BIT]) d.ok = 1'b0;
      end
      default: d.ok = 1'b0;
    endcase
    case (lat_c)
      LAT_2:   d.cfg.cas3 = 1'b0;
      LAT_3:   d.cfg.cas3 = 1'b1;
      default: d.ok = 1'b0;
    endcase
    case (pol_c)
      POL_BURST:  d.cfg.wr_one = 1'b0;
      POL_WR_ONE: d.cfg.wr_one = 1'b1;
      default:    d.ok = 1'b0;
    endcase
    return d;
  endfunction

  // beat-index mask for a non-full-page length
  function automatic logic [2:0] lg_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    return 3'b000;
      2'd1:    return 3'b001;
      2'd2:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/colseq_mode.sv
module colseq_mode
  import colseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [MODE_W-1:0] word,
  output mode_cfg_t         cfg,
  output logic              err
);

  mode_dec_t dec;
  mode_cfg_t cfg_nxt;
  logic      err_nxt;

  always_comb begin
    dec     = decode_mode(word);
    cfg_nxt = cfg;
    err_nxt = err;
    if (ld) begin
      if (dec.ok) cfg_nxt = dec.cfg;
      else        err_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
      err <= 1'b0;
    end else begin
      if (ld) begin
        cfg <= cfg_nxt;
        err <= err_nxt;
      end
    end
  end

endmodule

// File: rtl/colseq_addr.sv
module colseq_addr
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [1:0]       len_lg,
  input  logic             len_full,
  input  logic             intl,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] mix_low;

  always_comb begin
    mask    = len_full ? {COL_W{1'b1}} : COL_W'(lg_mask(len_lg));
    seq_low = base + beat;
    mix_low = base ^ beat;
  end

  // bits inside the burst block follow the order; bits above it stay put
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign addr[b] = mask[b] ? (intl ? mix_low[b] : seq_low[b]) : base[b];
  end

endmodule

// File: rtl/colseq_beat.sv
module colseq_beat
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             adv,
  input  logic             wr,
  input  logic [COL_W-1:0] start_col,
  input  mode_cfg_t        cfg,
  input  logic [COL_W-1:0] next_addr,
  output logic             active,
  output logic             last,
  output logic [COL_W-1:0] col_q,
  output logic [COL_W-1:0] beat_inc,
  output logic [COL_W-1:0] base_q,
  output logic [1:0]       lg_q,
  output logic             full_q,
  output logic             intl_q
);

  logic [COL_W-1:0] beat_q;
  logic             active_n;
  logic [COL_W-1:0] beat_n;
  logic [COL_W-1:0] col_n;
  logic [COL_W-1:0] base_n;
  logic [1:0]       lg_n;
  logic             full_n;
  logic             intl_n;
  logic             one_beat;
  logic             upd;

  assign beat_inc = beat_q + 1'b1;
  assign last     = active && !full_q && (beat_q == COL_W'(lg_mask(lg_q)));
  assign one_beat = wr && cfg.wr_one;
  assign upd      = start || stop || (active && adv);

  always_comb begin
    active_n = active;
    beat_n   = beat_q;
    col_n    = col_q;
    base_n   = base_q;
    lg_n     = lg_q;
    full_n   = full_q;
    intl_n   = intl_q;
    if (start) begin
      active_n = 1'b1;
      beat_n   = '0;
      col_n    = start_col;
      base_n   = start_col;
      lg_n     = one_beat ? 2'd0 : cfg.len_lg;
      full_n   = one_beat ? 1'b0 : cfg.len_full;
      intl_n   = cfg.intl;
    end else if (stop) begin
      active_n = 1'b0;
    end else if (active && adv) begin
      if (last) begin
        active_n = 1'b0;
      end else begin
        beat_n = beat_inc;
        col_n  = next_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat_q <= '0;
      col_q  <= '0;
      base_q <= '0;
      lg_q   <= 2'd0;
      full_q <= 1'b0;
      intl_q <= 1'b0;
    end else begin
      if (upd) begin
        active <= active_n;
        beat_q <= beat_n;
        col_q  <= col_n;
        base_q <= base_n;
        lg_q   <= lg_n;
        full_q <= full_n;
        intl_q <= intl_n;
      end
    end
  end

endmodule

// File: rtl/sdram_colseq.sv
module sdram_colseq
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              brst_start,
  input  logic              brst_write,
  input  logic [COL_W-1:0]  brst_col,
  input  logic              beat_adv,
  input  logic              brst_stop,
  output logic [COL_W-1:0]  col_addr,
  output logic              brst_active,
  output logic              brst_last,
  output logic [CAS_W-1:0]  cas_lat,
  output logic              cfg_err
);

  mode_cfg_t        cfg;
  logic [COL_W-1:0] beat_inc;
  logic [COL_W-1:0] base_q;
  logic [1:0]       lg_q;
  logic             full_q;
  logic             intl_q;
  logic [COL_W-1:0] next_addr;

  colseq_mode u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .ld   (mode_ld),
    .word (mode_word),
    .cfg  (cfg),
    .err  (cfg_err)
  );

  colseq_addr #(.COL_W(COL_W)) u_addr (
    .base    (base_q),
    .beat    (beat_inc),
    .len_lg  (lg_q),
    .len_full(full_q),
    .intl    (intl_q),
    .addr    (next_addr)
  );

  colseq_beat #(.COL_W(COL_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (brst_start),
    .stop     (brst_stop),
    .adv      (beat_adv),
    .wr       (brst_write),
    .start_col(brst_col),
    .cfg      (cfg),
    .next_addr(next_addr),
    .active   (brst_active),
    .last     (brst_last),
    .col_q    (col_addr),
    .beat_inc (beat_inc),
    .base_q   (base_q),
    .lg_q     (lg_q),
    .full_q   (full_q),
    .intl_q   (intl_q)
  );

  assign cas_lat = cfg.cas3 ? CAS_W'(3) : CAS_W'(2);

endmodule

// File: rtl/colseq_chk.sv
module colseq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_ld,
  input logic             brst_start,
  input logic [COL_W-1:0] brst_col,
  input logic             beat_adv,
  input logic             brst_stop,
  input logic [COL_W-1:0] col_addr,
  input logic             brst_active,
  input logic             brst_last,
  input logic [1:0]       cas_lat,
  input logic             cfg_err
);

  assert_start_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brst_start |=> (brst_active && col_addr == $past(brst_col)));

  assert_start_beats_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (brst_start && brst_stop) |=> brst_active);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (brst_active && !beat_adv && !brst_start && !brst_stop)
      |=> (brst_active && $stable(col_addr)));

  assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brst_last |-> brst_active);

  assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (brst_last && beat_adv && !brst_start) |=> !brst_active);

  assert_terminate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brst_stop && !brst_start) |=> !brst_active);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_lat_only_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ld |=> $stable(cas_lat));

  assert_lat_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2 || cas_lat == 2'd3));

endmodule

bind sdram_colseq colseq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_ld    (mode_ld),
  .brst_start (brst_start),
  .brst_col   (brst_col),
  .beat_adv   (beat_adv),
  .brst_stop  (brst_stop),
  .col_addr   (col_addr),
  .brst_active(brst_active),
  .brst_last  (brst_last),
  .cas_lat    (cas_lat),
  .cfg_err    (cfg_err)
);

// File: tb/sim_sdram_colseq.sv
module sim_sdram_colseq;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 8;
  localparam int ROW        = 1 << COL_W;

  logic             clk;
  logic             rst_n;
  logic             mode_ld;
  logic [11:0]      mode_word;
  logic             brst_start;
  logic             brst_write;
  logic [COL_W-1:0] brst_col;
  logic             beat_adv;
  logic             brst_stop;
  logic [COL_W-1:0] col_addr;
  logic             brst_active;
  logic             brst_last;
  logic [1:0]       cas_lat;
  logic             cfg_err;

  int n_vec;
  int n_bad;

  sdram_colseq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_word(mode_word),
    .brst_start(brst_start), .brst_write(brst_write), .brst_col(brst_col),
    .beat_adv(beat_adv), .brst_stop(brst_stop), .col_addr(col_addr),
    .brst_active(brst_active), .brst_last(brst_last), .cas_lat(cas_lat),
    .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] mw(input int pol, input int lat, input int ord, input int len);
    return {5'(pol), 3'(lat), 1'(ord), 3'(len)};
  endfunction

  function automatic int exp_col(input int st, input int k, input int len, input int intl);
    int base;
    int off;
    base = st - (st % len);
    off  = st % len;
    if (intl != 0) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  // start a burst, then advance every cycle and check every beat
  task automatic run_burst(input int st, input int wr, input int len, input int intl,
                           input int full, input int nbeats, input string req);
    brst_start = 1'b1;
    brst_col   = COL_W'(st);
    brst_write = wr[0];
    beat_adv   = 1'b1;
    @(negedge clk);
    brst_start = 1'b0;
    for (int k = 0; k < nbeats; k++) begin
      check({req, " col"}, int'(col_addr), exp_col(st, k, len, intl));
      check({req, " active"}, int'(brst_active), 1);
      check({req, " last"}, int'(brst_last), (full == 0 && k == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    if (full == 0) check({req, " end"}, int'(brst_active), 0);
    beat_adv = 1'b0;
  endtask

  task automatic load(input logic [11:0] w);
    mode_ld   = 1'b1;
    mode_word = w;
    @(negedge clk);
    mode_ld   = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; mode_ld = 1'b0; mode_word = '0; brst_start = 1'b0;
    brst_write = 1'b0; brst_col = '0; beat_adv = 1'b0; brst_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, then default single-beat sequential write burst
    check("R1 active", int'(brst_active), 0);
    check("R1 last", int'(brst_last), 0);
    check("R1 cas", int'(cas_lat), 2);
    check("R1 err", int'(cfg_err), 0);
    run_burst(5, 1, 1, 0, 0, 1, "R1 default burst");

    // R2 R3 R4 R7 R9: sweep lengths, orders, policies, directions, columns
    for (int len = 0; len < 4; len++)
      for (int ord = 0; ord < 2; ord++)
        for (int pol = 0; pol < 2; pol++) begin
          load(mw(pol * 4, 2 + ord, ord, len));
          check("R7 cas", int'(cas_lat), 2 + ord);
          check("R8 no err", int'(cfg_err), 0);
          for (int wr = 0; wr < 2; wr++)
            for (int c = 0; c < ROW; c += ((len == 3) ? 1 : 11)) begin
              int eff;
              eff = (wr == 1 && pol == 1) ? 1 : (1 << len);
              run_burst(c, wr, eff, ord, 0, eff,
                        (pol == 1 && wr == 1) ? "R9 single write" :
                        (ord == 1) ? "R4 interleave" : "R3 sequential");
            end
        end

    // R10: restart mid-burst, 8 beats sequential
    load(mw(0, 2, 0, 3));
    brst_start = 1'b1; brst_col = 8'd10; brst_write = 1'b0; beat_adv = 1'b1;
    @(negedge clk);
    brst_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R10 first col", int'(col_addr), 10 + k);
      @(negedge clk);
    end
    run_burst(37, 0, 8, 0, 0, 8, "R10 restart");

    // R11: advance low holds the beat
    load(mw(0, 2, 0, 2));
    brst_start = 1'b1; brst_col = 8'd4; beat_adv = 1'b0;
    @(negedge clk);
    brst_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R11 hold col", int'(col_addr), 4);
      check("R11 hold active", int'(brst_active), 1);
      @(negedge clk);
    end
    beat_adv = 1'b1;
    @(negedge clk);
    check("R11 advance col", int'(col_addr), 5);
    @(negedge clk);
    @(negedge clk);
    check("R11 last col", int'(col_addr), 7);
    check("R11 last flag", int'(brst_last), 1);
    @(negedge clk);
    check("R11 done", int'(brst_active), 0);
    beat_adv = 1'b0;

    // R5: full page wraps over the row, no last flag
    load(mw(0, 2, 0, 7));
    run_burst(250, 0, ROW, 0, 1, 300, "R5 full page");
    // R6: terminate
    brst_stop = 1'b1;
    @(negedge clk);
    brst_stop = 1'b0;
    check("R6 stop", int'(brst_active), 0);
    // R12: start wins over stop
    brst_start = 1'b1; brst_stop = 1'b1; brst_col = 8'd77;
    @(negedge clk);
    brst_start = 1'b0; brst_stop = 1'b0;
    check("R12 active", int'(brst_active), 1);
    check("R12 col", int'(col_addr), 77);
    brst_stop = 1'b1;
    @(negedge clk);
    brst_stop = 1'b0;
    check("R6 stop again", int'(brst_active), 0);

    // R8: reserved codes leave setting, set sticky error
    load(mw(0, 2, 0, 4));
    check("R8 err len100", int'(cfg_err), 1);
    run_burst(0, 0, ROW, 0, 1, 20, "R8 kept full page");
    brst_stop = 1'b1; @(negedge clk); brst_stop = 1'b0;
    load(mw(0, 3, 1, 7));
    check("R8 cas kept intl page", int'(cas_lat), 2);
    load(mw(0, 1, 0, 1));
    check("R8 cas kept lat001", int'(cas_lat), 2);
    load(mw(1, 3, 0, 1));
    check("R8 cas kept pol", int'(cas_lat), 2);
    run_burst(9, 0, ROW, 0, 1, 12, "R8 still full page");
    brst_stop = 1'b1; @(negedge clk); brst_stop = 1'b0;
    load(mw(0, 3, 0, 1));
    check("R7 cas3", int'(cas_lat), 3);
    check("R8 err sticky", int'(cfg_err), 1);
    run_burst(9, 1, 2, 0, 0, 2, "R2 two beat");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule